// File: doc/BRIEF.md
# DMA Channel Sequencer with Descriptor Chaining

This block runs one DMA channel. Software sets it up through a small register bank: a control word, a source address, a destination address, a transfer count and a descriptor pointer. It then sets the run bit. The sequencer moves data one unit at a time. Each unit is one 32-bit read of the source followed by one 32-bit write of that data to the destination. It moves a unit only when the selected request input is high. After each unit both addresses advance by one word and the count drops by one.

There are two modes.

- **Direct mode** uses the address and count registers exactly as software wrote them.
- **Chain mode** first reads a four-word descriptor from memory at the descriptor pointer. The words are source, destination, count and next-pointer, in that order. The sequencer loads the first three into the registers and runs them. It then follows a non-zero next-pointer to the next descriptor. A next-pointer of zero ends the chain.

On completion the hardware clears the run bit and sets a done flag. The done flag drives the interrupt unless it is masked.

Memory traffic uses a valid/ready request channel. A request stays asserted, with address, direction and write data unchanged, until the memory raises ready. Read data returns later on a response strobe that the sequencer always accepts. It issues only one read at a time and waits for that read's data before issuing anything else.

Top module: `dma_chan_seq`

## Requirements
- R1: Register byte offsets are: control 0x00, source 0x04, destination 0x08, count 0x0C, descriptor pointer 0x10. All registers reset to zero and read back what was written while the channel is idle.
- R2: Control bit positions are: run [0], direct [1], chain [2], request select [5:3], interrupt mask [6], done [7]. A transfer starts only when run is set together with direct or chain; chain wins if both are set. With run set and neither mode bit set, nothing happens and run stays set.
- R3: Each unit reads the word at the source address, then writes that same data to the destination address. Both addresses then step by +4 and the count decrements by one. This repeats until the count is zero.
- R4: Request select 0 is the software source, which is always requesting. Select values 1 to 4 pick req_i[0] to req_i[3]. Values 5 to 7 select nothing. A unit begins only while the selected input is high, and the other inputs have no effect.
- R5: mem_valid, once raised, stays high with mem_addr, mem_we and mem_wdata unchanged until a cycle with mem_ready high.
- R6: In chain mode, descriptor words are read from pointer +0, +4, +8 and +12 as source, destination, count and next. A non-zero next is copied into the descriptor pointer register and fetched in turn. A next of zero ends the chain and leaves the pointer register unchanged.
- R7: On completion, run clears and done is set in the same cycle. A count of zero completes with no memory writes.
- R8: irq is high exactly when done is set and mask is clear. Writing 1 to bit [7] clears done; writing 0 leaves it unchanged.
- R9: While a transfer is active:
  - writes to the source, destination, count and pointer registers are ignored;
  - control writes change only the request select, the mask and the done flag;
  - selecting no source stops further units until a valid source is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| req_i | input | 4 | Hardware request inputs |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Read data valid (always accepted) |
| mem_rdata | input | 32 | Read data |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach is a transfer parked part-way through its count. In that state the source selection can be switched off and back on, and register writes arrive that must be ignored. The stimulus gets there by picking a hardware request input and holding all the other inputs high. It then releases single one-cycle request pulses and reads the count between them, so the channel stays busy for as long as the bench needs. The memory model's ready signal is scrambled so that requests are held off at unpredictable points. A scoreboard compares every memory write against the expected source data, across a direct run and a two-descriptor chain.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int unsigned SELW = 3;

  localparam logic [4:0] OFF_CTRL = 5'h00;
  localparam logic [4:0] OFF_SRC  = 5'h04;
  localparam logic [4:0] OFF_DST  = 5'h08;
  localparam logic [4:0] OFF_CNT  = 5'h0C;
  localparam logic [4:0] OFF_DPTR = 5'h10;

  // bit order from lsb: run, direct, chain, sel[2:0], mask, done
  typedef struct packed {
    logic            done;
    logic            mask;
    logic [SELW-1:0] sel;
    logic            chain;
    logic            direct;
    logic            run;
  } ctrl_t;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_CHECK, S_WAIT, S_RD, S_RDW, S_WR, S_LINK
  } seq_state_e;
endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel
  import dma_seq_pkg::*;
#(
  parameter int unsigned NSRC = 5
) (
  input  logic [SELW-1:0] sel,
  input  logic [NSRC-2:0] req_i,
  output logic            req
);
  // select 0 is the software source and always requests
  always_comb begin
    req = (sel == '0);
    for (int k = 1; k < NSRC; k++) begin
      if (sel == SELW'(k)) req = req_i[k-1];
    end
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [4:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          busy,
  input  logic          ld_en,
  input  logic [1:0]    ld_idx,
  input  logic [AW-1:0] ld_data,
  input  logic          ld_dptr,
  input  logic          adv,
  input  logic          fin,
  output ctrl_t         ctrl,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic [AW-1:0] dptr
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
      dptr <= '0;
    end else begin
      if (we && addr == OFF_CTRL) begin
        ctrl.sel  <= wdata[5:3];
        ctrl.mask <= wdata[6];
        if (wdata[7]) ctrl.done <= 1'b0;
        if (!busy) begin
          ctrl.run    <= wdata[0];
          ctrl.direct <= wdata[1];
          ctrl.chain  <= wdata[2];
        end
      end
      if (we && !busy) begin
        case (addr)
          OFF_SRC:  src  <= AW'(wdata);
          OFF_DST:  dst  <= AW'(wdata);
          OFF_CNT:  cnt  <= CW'(wdata);
          OFF_DPTR: dptr <= AW'(wdata);
          default: ;
        endcase
      end
      if (ld_en) begin
        case (ld_idx)
          2'd0:    src <= ld_data;
          2'd1:    dst <= ld_data;
          default: cnt <= CW'(ld_data);
        endcase
      end
      if (ld_dptr) dptr <= ld_data;
      if (adv) begin
        src <= src + STEP;
        dst <= dst + STEP;
        cnt <= cnt - CW'(1);
      end
      if (fin) begin
        ctrl.run  <= 1'b0;
        ctrl.done <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      OFF_CTRL: rdata = DW'(ctrl);
      OFF_SRC:  rdata = DW'(src);
      OFF_DST:  rdata = DW'(dst);
      OFF_CNT:  rdata = DW'(cnt);
      OFF_DPTR: rdata = DW'(dptr);
      default:  rdata = '0;
    endcase
  end

  assert_cnt_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> cnt != '0);
  assert_done_clears_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.done) |-> !ctrl.run);
  assert_busy_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ld_en && !adv) |=> ($stable(src) && $stable(dst)));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          direct,
  input  logic          chain,
  input  logic          req,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] dptr,
  output logic          busy,
  output logic          ld_en,
  output logic [1:0]    ld_idx,
  output logic [AW-1:0] ld_data,
  output logic          ld_dptr,
  output logic          adv,
  output logic          fin,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  seq_state_e    state;
  logic [1:0]    widx;
  logic          chain_m;
  logic [AW-1:0] nxt;
  logic [DW-1:0] rbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      widx    <= '0;
      chain_m <= 1'b0;
      nxt     <= '0;
      rbuf    <= '0;
    end else begin
      case (state)
        S_IDLE: if (run && (direct || chain)) begin
          chain_m <= chain;
          widx    <= '0;
          state   <= chain ? S_FETCH : S_CHECK;
        end
        S_FETCH: if (mem_ready) state <= S_FWAIT;
        S_FWAIT: if (mem_rvalid) begin
          if (widx == 2'd3) begin
            nxt   <= AW'(mem_rdata);
            state <= S_CHECK;
          end else begin
            widx  <= widx + 2'd1;
            state <= S_FETCH;
          end
        end
        S_CHECK: state <= (cnt == '0) ? S_LINK : S_WAIT;
        S_WAIT:  if (req) state <= S_RD;
        S_RD:    if (mem_ready) state <= S_RDW;
        S_RDW:   if (mem_rvalid) begin
          rbuf  <= mem_rdata;
          state <= S_WR;
        end
        S_WR:    if (mem_ready) state <= S_CHECK;
        S_LINK: begin
          widx  <= '0;
          state <= (chain_m && nxt != '0) ? S_FETCH : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != S_IDLE);
    ld_en     = (state == S_FWAIT) && mem_rvalid && (widx != 2'd3);
    ld_idx    = widx;
    ld_data   = (state == S_LINK) ? nxt : AW'(mem_rdata);
    ld_dptr   = (state == S_LINK) && chain_m && (nxt != '0);
    adv       = (state == S_WR) && mem_ready;
    fin       = (state == S_LINK) && !(chain_m && nxt != '0);
    mem_valid = (state == S_FETCH) || (state == S_RD) || (state == S_WR);
    mem_we    = (state == S_WR);
    mem_wdata = (state == S_WR) ? rbuf : '0;
    case (state)
      S_FETCH: mem_addr = dptr + AW'({widx, 2'b00});
      S_RD:    mem_addr = src;
      S_WR:    mem_addr = dst;
      default: mem_addr = '0;
    endcase
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !(run && (direct || chain))) |=> state == S_IDLE);
  assert_req_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !req) |=> !mem_valid);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned CW   = 16,
  parameter int unsigned NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [4:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NSRC-2:0] req_i,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            irq
);
  ctrl_t         ctrl;
  logic [AW-1:0] src, dst, dptr, ld_data;
  logic [CW-1:0] cnt;
  logic          busy, ld_en, ld_dptr, adv, fin, req;
  logic [1:0]    ld_idx;

  dma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(ld_data), .ld_dptr(ld_dptr), .adv(adv), .fin(fin), .ctrl(ctrl),
    .src(src), .dst(dst), .cnt(cnt), .dptr(dptr)
  );

  dma_req_sel #(.NSRC(NSRC)) u_sel (
    .sel(ctrl.sel), .req_i(req_i), .req(req)
  );

  dma_engine #(.AW(AW), .DW(DW), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .direct(ctrl.direct),
    .chain(ctrl.chain), .req(req), .src(src), .dst(dst), .cnt(cnt), .dptr(dptr),
    .busy(busy), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .ld_dptr(ld_dptr), .adv(adv), .fin(fin), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  assign irq = ctrl.done && !ctrl.mask;
endmodule

// File: tb/tb_dma_chan_seq.sv
`timescale 1ns/1ps
module tb_dma_chan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  req_i = '0;
  logic        mem_valid, mem_we, mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        irq;

  logic [31:0] mem [0:255];
  typedef struct { logic [31:0] a; logic [31:0] d; } wr_t;
  wr_t exp_q[$];
  int checks = 0, errors = 0, nwrites = 0;
  logic [7:0]  lfsr = 8'hA7;
  logic        pend = 1'b0, pend_we = 1'b0;
  logic [31:0] pend_a = '0, pend_d = '0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  dma_chan_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_i(req_i),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model and scoreboard monitor
  always @(posedge clk) begin
    lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready  <= lfsr[0] | lfsr[2];
    mem_rvalid <= 1'b0;
    if (rst_n) begin
      if (pend)
        check(mem_valid && mem_addr == pend_a && mem_we == pend_we &&
              mem_wdata == pend_d, "R5", "request held", mem_addr, pend_a);
      pend    <= mem_valid && !mem_ready;
      pend_a  <= mem_addr;
      pend_we <= mem_we;
      pend_d  <= mem_wdata;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          mem[mem_addr[9:2]] <= mem_wdata;
          nwrites <= nwrites + 1;
          if (exp_q.size() == 0) begin
            check(1'b0, "R3", "unexpected write", mem_addr, 32'hFFFFFFFF);
          end else begin
            wr_t e;
            e = exp_q.pop_front();
            check(mem_addr == e.a, "R3/R6", "write addr", mem_addr, e.a);
            check(mem_wdata == e.d, "R3/R6", "write data", mem_wdata, e.d);
          end
        end else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[mem_addr[9:2]];
        end
      end
    end
  end

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(5'h00, c);
      if (!c[0]) break;
    end
  endtask

  task automatic expect_copy(input logic [31:0] s, input logic [31:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      wr_t e;
      e.a = d + 32'(4 * i);
      e.d = mem[s[9:2] + 8'(i)];
      exp_q.push_back(e);
    end
  endtask

  task automatic pulse_req(input int bitn);
    @(negedge clk);
    req_i = 4'(1 << bitn);
    @(negedge clk);
    req_i = '0;
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "ALL", "watchdog", 32'd0, 32'd1);
    summary();
  end

  initial begin
    int w0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + 32'(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      reg_rd(5'(4 * i), rv);
      check(rv == 0, "R1", "reset value", rv, 0);
    end
    check(irq == 1'b0, "R8", "irq after reset", 32'(irq), 0);

    // R1 readback
    reg_wr(5'h04, 32'h40); reg_wr(5'h08, 32'h80);
    reg_wr(5'h0C, 32'd3);  reg_wr(5'h10, 32'h200);
    reg_rd(5'h04, rv); check(rv == 32'h40, "R1", "src readback", rv, 32'h40);
    reg_rd(5'h08, rv); check(rv == 32'h80, "R1", "dst readback", rv, 32'h80);
    reg_rd(5'h0C, rv); check(rv == 32'd3, "R1", "cnt readback", rv, 3);
    reg_rd(5'h10, rv); check(rv == 32'h200, "R1", "dptr readback", rv, 32'h200);

    // R2 run without a mode bit does nothing
    reg_wr(5'h00, 32'h01);
    repeat (20) @(negedge clk);
    reg_rd(5'h00, rv); check(rv == 32'h01, "R2", "run kept, no start", rv, 32'h01);
    reg_rd(5'h04, rv); check(rv == 32'h40, "R2", "src untouched", rv, 32'h40);
    check(nwrites == 0, "R2", "no writes", 32'(nwrites), 0);
    reg_wr(5'h00, 32'h00);

    // R3/R7/R8 direct mode, software source
    expect_copy(32'h40, 32'h80, 3);
    reg_wr(5'h00, 32'h03);
    wait_idle();
    reg_rd(5'h00, rv); check(rv == 32'h82, "R7", "done set, run cleared", rv, 32'h82);
    reg_rd(5'h04, rv); check(rv == 32'h4C, "R3", "src stepped", rv, 32'h4C);
    reg_rd(5'h08, rv); check(rv == 32'h8C, "R3", "dst stepped", rv, 32'h8C);
    reg_rd(5'h0C, rv); check(rv == 0, "R3", "count zero", rv, 0);
    check(exp_q.size() == 0, "R3", "all writes seen", 32'(exp_q.size()), 0);
    check(irq == 1'b1, "R8", "irq raised", 32'(irq), 1);
    reg_wr(5'h00, 32'h80);
    reg_rd(5'h00, rv); check(rv == 0, "R8", "done cleared by W1C", rv, 0);
    check(irq == 1'b0, "R8", "irq dropped", 32'(irq), 0);

    // R4/R9 hardware request on req_i[1] (select 2)
    reg_wr(5'h04, 32'h60); reg_wr(5'h08, 32'hC0); reg_wr(5'h0C, 32'd2);
    expect_copy(32'h60, 32'hC0, 2);
    w0 = nwrites;
    reg_wr(5'h00, 32'h13);
    @(negedge clk); req_i = 4'b1101;
    repeat (30) @(negedge clk);
    req_i = '0;
    reg_rd(5'h0C, rv); check(rv == 2, "R4", "other inputs ignored", rv, 2);
    check(nwrites == w0, "R4", "no writes without request", 32'(nwrites), 32'(w0));
    reg_wr(5'h04, 32'h3F0);
    reg_rd(5'h04, rv); check(rv == 32'h60, "R9", "src write ignored while busy", rv, 32'h60);
    pulse_req(1);
    reg_rd(5'h0C, rv); check(rv == 1, "R4", "one unit per request", rv, 1);
    reg_wr(5'h00, 32'h38);
    reg_rd(5'h00, rv); check(rv == 32'h3B, "R9", "only select changed while busy", rv, 32'h3B);
    pulse_req(1);
    reg_rd(5'h0C, rv); check(rv == 1, "R9", "deselected source ignored", rv, 1);
    reg_wr(5'h00, 32'h10);
    pulse_req(1);
    wait_idle();
    reg_rd(5'h00, rv); check(rv == 32'h92, "R7", "done after hw requests", rv, 32'h92);
    check(exp_q.size() == 0, "R4", "all writes seen", 32'(exp_q.size()), 0);
    reg_wr(5'h00, 32'h80);

    // R7/R8 zero count with mask set
    w0 = nwrites;
    reg_wr(5'h0C, 32'd0);
    reg_wr(5'h00, 32'h43);
    wait_idle();
    reg_rd(5'h00, rv); check(rv == 32'hC2, "R7", "zero count completes", rv, 32'hC2);
    check(nwrites == w0, "R7", "zero count no writes", 32'(nwrites), 32'(w0));
    check(irq == 1'b0, "R8", "masked irq", 32'(irq), 0);
    reg_wr(5'h00, 32'h80);

    // R6 two-descriptor chain
    mem[8'h80] = 32'h100; mem[8'h81] = 32'h300; mem[8'h82] = 32'd2; mem[8'h83] = 32'h210;
    mem[8'h84] = 32'h120; mem[8'h85] = 32'h340; mem[8'h86] = 32'd1; mem[8'h87] = 32'h0;
    reg_wr(5'h10, 32'h200);
    expect_copy(32'h100, 32'h300, 2);
    expect_copy(32'h120, 32'h340, 1);
    reg_wr(5'h00, 32'h05);
    wait_idle();
    reg_rd(5'h00, rv); check(rv == 32'h84, "R7", "chain done", rv, 32'h84);
    reg_rd(5'h10, rv); check(rv == 32'h210, "R6", "pointer followed", rv, 32'h210);
    reg_rd(5'h04, rv); check(rv == 32'h124, "R6", "src from 2nd descriptor", rv, 32'h124);
    reg_rd(5'h08, rv); check(rv == 32'h344, "R6", "dst from 2nd descriptor", rv, 32'h344);
    reg_rd(5'h0C, rv); check(rv == 0, "R6", "count zero", rv, 0);
    check(exp_q.size() == 0, "R6", "all chain writes seen", 32'(exp_q.size()), 0);
    check(irq == 1'b1, "R8", "irq after chain", 32'(irq), 1);

    summary();
  end
endmodule